// File: doc/BRIEF.md
# Reference Clock Source Selector with Failover

This block picks which of four line ports supplies its recovered clock as the shared system reference. A host writes one 8-bit control word. The control word names the master port, the backup used when the transmit clock is lost, a rate code for the high-speed synthesizer, the synthesizer output enable and an enable for the alternate jitter attenuator. The clock paths themselves are modelled as select and enable signals sampled on one system clock. No clock edge is gated here.

Each port reports carrier loss, and the transmit side reports loss of its clock. Both inputs pass through synchronizers before use. If the chosen master port loses carrier, the reference falls back to the local backup master clock. That fallback is latched, so it holds even after the carrier returns, and only a fresh host write releases it. The rate code becomes a divided enable pulse taken from a base tick at the highest rate. The rate changes only on a divider boundary, so no pulse period is ever cut short.

Top module: `ref_clock_failover`

## Requirements
- R1: After reset the control word is 0x00. No port is selected, the reference pin is not driven, the synthesizer output is disabled, and the failover, transmit-backup and jitter outputs are all 0.
- R2: Master code (bits 2:0) 1, 2, 3 or 4 sets exactly bit 0, 1, 2 or 3 of `src_port_o` and raises `ref_drive_o`, starting in the cycle after the write.
- R3: Master code 0 and the reserved codes 5, 6 and 7 select no port and leave `ref_drive_o` low. With these codes, carrier loss never causes a failover.
- R4: Carrier loss on the selected port raises `failover_o` and clears `src_port_o` on the third clock edge after the input rises. `ref_drive_o` stays high.
- R5: Carrier loss on a port that is not selected has no effect on any output.
- R6: `failover_o` stays set after the carrier returns. Any register write clears it on that write's edge. If the loss is still present, it sets again on a later edge.
- R7: When the transmit-clock-loss input has been high for two edges, bit 6 picks the backup: 0 raises `tx_use_mclk_o` and 1 raises `tx_use_sysref_o`. Both outputs follow the input and are never high together.
- R8: `syn_oe_o` follows bit 5 and `jit_alt_o` follows bit 7.
- R9: Rate code (bits 4:3) 00, 01, 10 or 11 gives one `syn_tick_o` every 8, 4, 2 or 1 base ticks.
- R10: A new rate code takes effect only after the current divider period ends. The gap between two ticks is always a whole period of either the old rate or the new rate.
- R11: `syn_tick_o` is high only in cycles where `base_tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word value |
| base_tick_i | input | 1 | Enable tick at the highest synthesizer rate |
| carrier_loss_i | input | 4 | Per-port receive carrier loss, asynchronous |
| tx_clk_loss_i | input | 1 | Transmit clock loss, asynchronous |
| src_port_o | output | 4 | One-hot port that sources the reference |
| ref_drive_o | output | 1 | Shared reference pin driven by this block |
| failover_o | output | 1 | Reference switched to local backup clock (sticky) |
| tx_use_mclk_o | output | 1 | Transmit uses the local master clock |
| tx_use_sysref_o | output | 1 | Transmit uses the system reference |
| syn_oe_o | output | 1 | Synthesizer output driven |
| syn_tick_o | output | 1 | Divided synthesizer enable pulse |
| jit_alt_o | output | 1 | Alternate jitter attenuator enabled |

## Verification
Suppose the failover latch holds the wrong value. The one-hot port select then shows it on the next edge, either as a live port during failover or as a failover that persists after a write. Suppose instead the divider state is wrong. That appears within one full period of eight base ticks, as a wrong tick count over a window or a single gap that differs from both the old and the new period. Faults in the synchronizer depth show up as an output that changes one edge early or one edge late in the cycle-exact failover and transmit-loss checks.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   localparam int CTRL_W = 8;
   localparam int MSEL_W = 3;
   localparam int RATE_W = 2;

   // field layout of the control word, most significant first
   typedef struct packed {
      logic              jit_alt;
      logic              bkup_sys;
      logic              syn_oe;
      logic [RATE_W-1:0] rate;
      logic [MSEL_W-1:0] master;
   } ctrl_t;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= '0;
         else if (s == 0) stg[s] <= d_i;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/refsel_rate_div.sv
module refsel_rate_div #(
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              tick_o
);
   localparam int MAX_SH = (1 << RATE_W) - 1;
   localparam int CNT_W  = (MAX_SH < 1) ? 1 : MAX_SH;

   logic [RATE_W-1:0] act_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W:0]    one_sh;
   logic [CNT_W-1:0]  lim;
   logic              terminal;

   always_comb begin
      one_sh   = (CNT_W+1)'(1) << (RATE_W'(MAX_SH) - act_q);
      lim      = CNT_W'(one_sh - (CNT_W+1)'(1));
      terminal = (cnt_q == lim);
   end

   assign tick_o = base_tick_i & terminal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (base_tick_i) begin
         if (terminal) begin
            cnt_q <= '0;
            act_q <= rate_i;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/ref_clock_failover.sv
module ref_clock_failover
   import refsel_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [CTRL_W-1:0]    wr_data_i,
   input  logic                 base_tick_i,
   input  logic [NUM_PORTS-1:0] carrier_loss_i,
   input  logic                 tx_clk_loss_i,
   output logic [NUM_PORTS-1:0] src_port_o,
   output logic                 ref_drive_o,
   output logic                 failover_o,
   output logic                 tx_use_mclk_o,
   output logic                 tx_use_sysref_o,
   output logic                 syn_oe_o,
   output logic                 syn_tick_o,
   output logic                 jit_alt_o
);
   localparam int SYNC_W = NUM_PORTS + 1;

   if (NUM_PORTS < 1 || NUM_PORTS > (1 << MSEL_W) - 1)
      $error("NUM_PORTS does not fit the master select field");
   if (SYNC_STAGES < 2)
      $error("SYNC_STAGES must be at least 2");

   ctrl_t                ctrl_q;
   logic [SYNC_W-1:0]    loss_s;
   logic [NUM_PORTS-1:0] cl_s;
   logic                 txl_s;
   logic [NUM_PORTS-1:0] sel_hit;
   logic                 fo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_en_i) ctrl_q <= ctrl_t'(wr_data_i);
   end

   refsel_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({tx_clk_loss_i, carrier_loss_i}),
      .q_o   (loss_s)
   );
   assign cl_s  = loss_s[NUM_PORTS-1:0];
   assign txl_s = loss_s[NUM_PORTS];

   // code p+1 picks port p; zero and out-of-range codes pick nothing
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
      assign sel_hit[p] = (ctrl_q.master == MSEL_W'(p + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 fo_q <= 1'b0;
      else if (wr_en_i)           fo_q <= 1'b0;
      else if (|(sel_hit & cl_s)) fo_q <= 1'b1;
   end

   assign src_port_o      = fo_q ? '0 : sel_hit;
   assign ref_drive_o     = |sel_hit;
   assign failover_o      = fo_q;
   assign tx_use_mclk_o   = txl_s & ~ctrl_q.bkup_sys;
   assign tx_use_sysref_o = txl_s &  ctrl_q.bkup_sys;
   assign syn_oe_o        = ctrl_q.syn_oe;
   assign jit_alt_o       = ctrl_q.jit_alt;

   refsel_rate_div #(.RATE_W(RATE_W)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .base_tick_i (base_tick_i),
      .rate_i      (ctrl_q.rate),
      .tick_o      (syn_tick_o)
   );
endmodule

// File: rtl/ref_clock_failover_chk.sv
module ref_clock_failover_chk #(
   parameter int NUM_PORTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en_i,
   input logic                 base_tick_i,
   input logic [NUM_PORTS-1:0] src_port_o,
   input logic                 ref_drive_o,
   input logic                 failover_o,
   input logic                 tx_use_mclk_o,
   input logic                 tx_use_sysref_o,
   input logic                 syn_tick_o
);
   logic [3:0] bt_gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bt_gap <= '0;
      else if (base_tick_i) bt_gap <= syn_tick_o ? 4'd0 : bt_gap + 4'd1;
   end

   // R2
   onehot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_port_o));
   // R4
   fo_no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      failover_o |-> (src_port_o == '0) && ref_drive_o);
   // R3
   src_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_drive_o |-> (src_port_o == '0) && !failover_o);
   // R6
   fo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (failover_o && !wr_en_i) |=> failover_o);
   // R6
   fo_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> !failover_o);
   // R7
   tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_use_mclk_o && tx_use_sysref_o));
   // R11
   tick_on_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      syn_tick_o |-> base_tick_i);
   // R10
   whole_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      syn_tick_o |-> ($countones(bt_gap + 4'd1) == 1) && (bt_gap < 4'd8));
endmodule

bind ref_clock_failover ref_clock_failover_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en_i         (wr_en_i),
   .base_tick_i     (base_tick_i),
   .src_port_o      (src_port_o),
   .ref_drive_o     (ref_drive_o),
   .failover_o      (failover_o),
   .tx_use_mclk_o   (tx_use_mclk_o),
   .tx_use_sysref_o (tx_use_sysref_o),
   .syn_tick_o      (syn_tick_o)
);

// File: tb/test_ref_clock_failover.sv
module test_ref_clock_failover;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       base_tick_i = 1'b1;
   logic [3:0] carrier_loss_i = '0;
   logic       tx_clk_loss_i = 1'b0;
   logic [3:0] src_port_o;
   logic       ref_drive_o, failover_o, tx_use_mclk_o, tx_use_sysref_o;
   logic       syn_oe_o, syn_tick_o, jit_alt_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ref_clock_failover i_ref_clock_failover (
      .clk, .rst_n, .wr_en_i, .wr_data_i, .base_tick_i, .carrier_loss_i,
      .tx_clk_loss_i, .src_port_o, .ref_drive_o, .failover_o, .tx_use_mclk_o,
      .tx_use_sysref_o, .syn_oe_o, .syn_tick_o, .jit_alt_o
   );

   // data[22:15] loss[14:11] txl[10] src[9:6] drv[5] fo[4] txm[3] txs[2] oe[1] alt[0]
   localparam int NV = 17;
   localparam logic [22:0] VEC [NV] = '{
      {8'h01, 4'b0000, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h02, 4'b0000, 1'b0, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h03, 4'b0000, 1'b0, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h04, 4'b0000, 1'b0, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h05, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h06, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h07, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h00, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h02, 4'b0010, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h02, 4'b1101, 1'b0, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h00, 4'b1111, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h06, 4'b1111, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h20, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'h40, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'h40, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h80, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'hE4, 4'b1000, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_data_i = d;
      @(negedge clk);
      wr_en_i   = 1'b0;
   endtask

   task automatic count_ticks(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (syn_tick_o) cnt++;
      end
   endtask

   task automatic gap_to_tick(output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!syn_tick_o && g < 40);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int n;
      int g;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({4'b0, src_port_o}, 8'h00, "R1 src_port");
      chk({7'b0, ref_drive_o}, 8'h00, "R1 ref_drive");
      chk({6'b0, failover_o, syn_oe_o}, 8'h00, "R1 failover/oe");
      chk({5'b0, tx_use_mclk_o, tx_use_sysref_o, jit_alt_o}, 8'h00, "R1 tx/jit");

      // vector walk: R2 R3 R4 R5 R7 R8
      for (int v = 0; v < NV; v++) begin
         carrier_loss_i = '0;
         tx_clk_loss_i  = 1'b0;
         repeat (4) @(negedge clk);
         wr(VEC[v][22:15]);
         carrier_loss_i = VEC[v][14:11];
         tx_clk_loss_i  = VEC[v][10];
         repeat (4) @(negedge clk);
         chk({4'b0, src_port_o}, {4'b0, VEC[v][9:6]}, $sformatf("R2 R3 R5 src vec%0d", v));
         chk({7'b0, ref_drive_o}, {7'b0, VEC[v][5]}, $sformatf("R2 R3 drive vec%0d", v));
         chk({7'b0, failover_o}, {7'b0, VEC[v][4]}, $sformatf("R4 R5 failover vec%0d", v));
         chk({6'b0, tx_use_mclk_o, tx_use_sysref_o}, {6'b0, VEC[v][3:2]}, $sformatf("R7 tx vec%0d", v));
         chk({6'b0, syn_oe_o, jit_alt_o}, {6'b0, VEC[v][1:0]}, $sformatf("R8 oe/jit vec%0d", v));
      end
      carrier_loss_i = '0;
      tx_clk_loss_i  = 1'b0;
      repeat (4) @(negedge clk);

      // R4 failover timing: third edge after input
      wr(8'h03);
      carrier_loss_i = 4'b0100;
      @(negedge clk); @(negedge clk);
      chk({7'b0, failover_o}, 8'h00, "R4 not yet after two edges");
      @(negedge clk);
      chk({7'b0, failover_o}, 8'h01, "R4 set on third edge");
      chk({4'b0, src_port_o}, 8'h00, "R4 port dropped");

      // R6 sticky after carrier returns
      carrier_loss_i = '0;
      repeat (6) @(negedge clk);
      chk({7'b0, failover_o}, 8'h01, "R6 sticky after carrier returns");
      wr(8'h03);
      chk({7'b0, failover_o}, 8'h00, "R6 cleared by write");
      chk({4'b0, src_port_o}, 8'h04, "R6 port restored");
      // R6 re-latch while loss persists
      carrier_loss_i = 4'b0100;
      repeat (4) @(negedge clk);
      @(negedge clk);
      wr_en_i = 1'b1; wr_data_i = 8'h03;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk({7'b0, failover_o}, 8'h00, "R6 write clears on its edge");
      @(negedge clk);
      chk({7'b0, failover_o}, 8'h01, "R6 relatch with loss present");
      carrier_loss_i = '0;
      wr(8'h00);

      // R7 transmit loss timing
      wr(8'h40);
      tx_clk_loss_i = 1'b1;
      @(negedge clk);
      chk({7'b0, tx_use_sysref_o}, 8'h00, "R7 not yet after one edge");
      @(negedge clk);
      chk({7'b0, tx_use_sysref_o}, 8'h01, "R7 sysref after two edges");
      tx_clk_loss_i = 1'b0;
      repeat (3) @(negedge clk);
      chk({6'b0, tx_use_mclk_o, tx_use_sysref_o}, 8'h00, "R7 follows input low");

      // R9 rate windows with continuous base ticks
      for (int r = 0; r < 4; r++) begin
         wr(8'(r << 3));
         repeat (16) @(negedge clk);
         count_ticks(64, n);
         chk(8'(n), 8'(64 >> (3 - r)), $sformatf("R9 ticks in 64 at rate %0d", r));
      end

      // R10 slow to fast: write mid-period
      wr(8'h00);
      repeat (16) @(negedge clk);
      gap_to_tick(g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
         if (g == 3) begin wr_en_i = 1'b1; wr_data_i = 8'h18; end
         else wr_en_i = 1'b0;
      end while (!syn_tick_o && g < 40);
      chk(8'(g), 8'd8, "R10 old period completes");
      gap_to_tick(g);
      chk(8'(g), 8'd1, "R10 new fast period");
      // R10 fast to slow
      wr_en_i = 1'b1; wr_data_i = 8'h00;
      gap_to_tick(g);
      wr_en_i = 1'b0;
      chk(8'(g), 8'd1, "R10 last fast tick");
      gap_to_tick(g);
      chk(8'(g), 8'd8, "R10 slow period after boundary");

      // R11 no base tick, no output tick
      base_tick_i = 1'b0;
      count_ticks(32, n);
      chk(8'(n), 8'd0, "R11 no ticks without base tick");
      // R11 sparse base ticks at fastest rate
      wr(8'h18);
      n = 0;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         base_tick_i = (i % 3 == 0);
         #1;
         if (syn_tick_o !== base_tick_i) n++;
      end
      chk(8'(n), 8'd0, "R11 tick tracks base tick");

      finish_run();
   end
endmodule